// File: doc/BRIEF.md
# Shared Multiplexer Bus Register Transfer

This block holds three parallel-load registers that exchange data over one shared bus. A single three-way multiplexer places exactly one register on the bus. A two-bit select code picks that source. One load bit per register decides which registers capture the bus value at the next rising clock edge. Any set of destinations may load in the same cycle, including the source register itself. Because there is only one bus, a transfer that needs two different sources takes at least two cycles. The surrounding control must order such transfers itself.

The fourth select code has no source. When it is applied, the bus carries zero and an error flag rises in that same cycle. No register takes a bus value in that cycle, whatever the load bits say. A separate write port loads a chosen register directly, so registers can be initialised and test values placed. A synchronous reset clears all three registers.

Top module: `mbus_transfer`

## Requirements
- R1: Select code 0 places register 0 on the bus, code 1 places register 1, and code 2 places register 2. The bus output follows the select combinationally, in the same cycle.
- R2: When the select is valid, every register whose load bit is high holds the bus value after the next rising edge. Any number of load bits may be high together (load bit i belongs to register i).
- R3: A register whose load bit is low, and that the write port does not target, keeps its value across the edge.
- R4: A register that is both the selected source and a loaded destination reloads its own value, so it stays unchanged.
- R5: Select code 3 drives zero onto the bus and raises the error flag in the same cycle. At the following edge no register takes a bus value, even with load bits high.
- R6: The error flag is low whenever the select code is 0, 1 or 2.
- R7: While the synchronous reset is high at a rising edge, all three registers become zero.
- R8: When the write enable is high and the write index is 0, 1 or 2, that register takes the write data at the edge. This overrides its load bit, while the other registers still follow their load bits. Write index 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | 2 | Bus source code (0..2 valid, 3 invalid) |
| load_i | input | 3 | Per-register capture enables, bit i for register i |
| wr_en_i | input | 1 | Direct write enable |
| wr_idx_i | input | 2 | Direct write target register |
| wr_data_i | input | DATA_W | Direct write value |
| regs_o | output | 3 x DATA_W | Current register contents, element i is register i |
| bus_o | output | DATA_W | Current bus value |
| sel_err_o | output | 1 | High while the select code has no source |

## Verification
If a register's internal value is wrong, two things show at the ports. The register output is wrong from the first edge after the fault. When that register is then selected, the bus is wrong in the same cycle. If load decoding is wrong, a wrong destination changes or fails to change, and this is visible one cycle after the transfer. A fault in the source or invalid-code logic shows at once on the bus and the error flag, before any edge. The sweep covers every select code with every load pattern and every write index. It starts from fresh, distinct register values, so a swapped or missing path cannot hide behind equal data.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int NUM_REGS = 3;
    localparam int SEL_W    = $clog2(NUM_REGS + 1);

    typedef enum logic [SEL_W-1:0] {
        SRC_REG0  = 2'd0,
        SRC_REG1  = 2'd1,
        SRC_REG2  = 2'd2,
        SRC_NONE  = 2'd3
    } src_sel_e;

endpackage

// File: rtl/mbus_src_mux.sv
module mbus_src_mux
    import mbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [SEL_W-1:0]                 sel_i,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_i,
    output logic [DATA_W-1:0]                bus_o,
    output logic                             valid_o
);

    logic [NUM_REGS-1:0]             hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] gated;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_src
        assign hit[g]   = (sel_i == SEL_W'(g));
        assign gated[g] = regs_i[g] & {DATA_W{hit[g]}};
    end

    always_comb begin
        bus_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            bus_o = bus_o | gated[i];
        end
    end

    assign valid_o = |hit;

endmodule

// File: rtl/mbus_load_ctrl.sv
module mbus_load_ctrl
    import mbus_pkg::*;
(
    input  logic [NUM_REGS-1:0] load_i,
    input  logic                src_valid_i,
    input  logic                wr_en_i,
    input  logic [SEL_W-1:0]    wr_idx_i,
    output logic [NUM_REGS-1:0] bus_ld_o,
    output logic [NUM_REGS-1:0] wr_ld_o
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_ld
        assign wr_ld_o[g]  = wr_en_i && (wr_idx_i == SEL_W'(g));
        assign bus_ld_o[g] = load_i[g] && src_valid_i && !wr_ld_o[g];
    end

endmodule

// File: rtl/mbus_reg_bank.sv
module mbus_reg_bank
    import mbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic [NUM_REGS-1:0]              bus_ld_i,
    input  logic [NUM_REGS-1:0]              wr_ld_i,
    input  logic [DATA_W-1:0]                bus_i,
    input  logic [DATA_W-1:0]                wr_data_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } bank_t;

    bank_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_ld_i[i]) begin
                state_d.regs[i] = wr_data_i;
            end else if (bus_ld_i[i]) begin
                state_d.regs[i] = bus_i;
            end
        end
        if (rst_i) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign regs_o = state_q.regs;

    p_reset_clear_r7: assert property (@(posedge clk_i)
        rst_i |=> (regs_o == '0));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
            (!bus_ld_i[g] && !wr_ld_i[g]) |=> $stable(regs_o[g]));

        p_capture_bus_r2: assert property (@(posedge clk_i) disable iff (rst_i)
            bus_ld_i[g] |=> (regs_o[g] == $past(bus_i)));

        p_direct_write_r8: assert property (@(posedge clk_i) disable iff (rst_i)
            wr_ld_i[g] |=> (regs_o[g] == $past(wr_data_i)));
    end

endmodule

// File: rtl/mbus_transfer.sv
module mbus_transfer
    import mbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic [SEL_W-1:0]                 sel_i,
    input  logic [NUM_REGS-1:0]              load_i,
    input  logic                             wr_en_i,
    input  logic [SEL_W-1:0]                 wr_idx_i,
    input  logic [DATA_W-1:0]                wr_data_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o,
    output logic [DATA_W-1:0]                bus_o,
    output logic                             sel_err_o
);

    logic                             src_valid;
    logic [NUM_REGS-1:0]              bus_ld;
    logic [NUM_REGS-1:0]              wr_ld;
    logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q;
    logic [DATA_W-1:0]                bus_d;

    mbus_src_mux #(.DATA_W(DATA_W)) u_mux (
        .sel_i   (sel_i),
        .regs_i  (regs_q),
        .bus_o   (bus_d),
        .valid_o (src_valid)
    );

    mbus_load_ctrl u_ctrl (
        .load_i      (load_i),
        .src_valid_i (src_valid),
        .wr_en_i     (wr_en_i),
        .wr_idx_i    (wr_idx_i),
        .bus_ld_o    (bus_ld),
        .wr_ld_o     (wr_ld)
    );

    mbus_reg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .bus_ld_i  (bus_ld),
        .wr_ld_i   (wr_ld),
        .bus_i     (bus_d),
        .wr_data_i (wr_data_i),
        .regs_o    (regs_q)
    );

    assign regs_o    = regs_q;
    assign bus_o     = bus_d;
    assign sel_err_o = !src_valid;

    p_bus_source_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i != SRC_NONE) |-> (bus_o == regs_o[sel_i]));

    p_invalid_zero_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i == SRC_NONE) |-> (bus_o == '0 && sel_err_o));

    p_invalid_freeze_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i == SRC_NONE && !wr_en_i) |=> $stable(regs_o));

    p_err_low_valid_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i != SRC_NONE) |-> !sel_err_o);

endmodule

// File: tb/mbus_transfer_test.sv
`timescale 1ns/1ps
module mbus_transfer_test;

    localparam int W = 8;

    logic            clk = 1'b0;
    logic            rst;
    logic [1:0]      sel;
    logic [2:0]      load;
    logic            wr_en;
    logic [1:0]      wr_idx;
    logic [W-1:0]    wr_data;
    logic [2:0][W-1:0] regs;
    logic [W-1:0]    bus;
    logic            err;

    int n_chk  = 0;
    int n_fail = 0;
    logic [W-1:0] exp_r [3];

    always #5 clk = ~clk;

    mbus_transfer #(.DATA_W(W)) uut (
        .clk_i     (clk),
        .rst_i     (rst),
        .sel_i     (sel),
        .load_i    (load),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .regs_o    (regs),
        .bus_o     (bus),
        .sel_err_o (err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] bexp;
        string tag;
        rst = 1'b1; sel = 2'd0; load = 3'd0; wr_en = 1'b0; wr_idx = 2'd0; wr_data = '0;
        repeat (2) @(posedge clk);
        #1;
        for (int i = 0; i < 3; i++) chk("R7 reset clears register", 32'(regs[i]), 32'd0);
        rst = 1'b0;

        for (int s = 0; s < 4; s++) begin
            for (int l = 0; l < 8; l++) begin
                for (int m = 0; m < 5; m++) begin
                    // preset distinct values through the write port (R8)
                    sel = 2'd0; load = 3'd0;
                    for (int i = 0; i < 3; i++) begin
                        wr_en = 1'b1; wr_idx = 2'(i);
                        wr_data = W'(s * 53 + l * 29 + m * 17 + i * 71 + 3);
                        exp_r[i] = wr_data;
                        @(posedge clk);
                        #1;
                    end
                    for (int i = 0; i < 3; i++) chk("R8 preset write", 32'(regs[i]), 32'(exp_r[i]));
                    // transfer cycle
                    sel = 2'(s); load = 3'(l);
                    wr_en = (m != 0); wr_idx = (m != 0) ? 2'(m - 1) : 2'd0;
                    wr_data = W'(s * 7 + l * 13 + m * 101 + 200);
                    #1;
                    bexp = (s < 3) ? exp_r[s] : '0;
                    chk((s < 3) ? "R1 bus carries source" : "R5 bus zero on code 3", 32'(bus), 32'(bexp));
                    chk((s < 3) ? "R6 err low on valid code" : "R5 err high on code 3",
                        32'(err), (s < 3) ? 32'd0 : 32'd1);
                    @(posedge clk);
                    #1;
                    for (int i = 0; i < 3; i++) begin
                        if (m != 0 && (m - 1) == i) begin
                            tag = "R8 write overrides load";
                            exp_r[i] = wr_data;
                        end else if (s == 3) begin
                            tag = "R5 no capture on code 3";
                        end else if (l[i]) begin
                            tag = (s == i) ? "R4 self-load unchanged" : "R2 destination captures bus";
                            exp_r[i] = bexp;
                        end else begin
                            tag = "R3 unloaded register holds";
                        end
                        chk(tag, 32'(regs[i]), 32'(exp_r[i]));
                    end
                    wr_en = 1'b0;
                end
            end
        end

        // reset wins over pending loads and writes
        sel = 2'd1; load = 3'b111; wr_en = 1'b1; wr_idx = 2'd0; wr_data = 8'h5A;
        rst = 1'b1;
        @(posedge clk);
        #1;
        for (int i = 0; i < 3; i++) chk("R7 reset during transfer", 32'(regs[i]), 32'd0);
        rst = 1'b0; wr_en = 1'b0; load = 3'd0;
        @(posedge clk);
        #1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule